// File: doc/BRIEF.md
# Almost-Empty / Almost-Full Offset Register Bank

This block holds the two threshold offsets that a FIFO's flag logic uses. The empty offset sets how close to empty the almost-empty flag fires. The full offset does the same for almost-full. Both offsets are unsigned values in the range 0 to DEPTH-1 and drive the `empty_ofs` and `full_ofs` outputs continuously.

While master reset is held, the block samples three strap inputs. One strap picks how the offsets are rewritten later: by whole words on a parallel port, or one bit per clock on a serial port. The same strap and a two-bit select together choose one of eight preset values, and that value is loaded into both offsets. After reset, the offsets can be rewritten any number of times with the chosen method. The other method is ignored.

Readback always goes through the parallel output, whichever method is active. A word write and a word read each have their own internal pointer. Each pointer alternates between the empty offset and the full offset, starting with the empty offset after every reset.

Top module: `flag_offset_bank`

## Requirements
- R1: While `mrst` is high, `mode_serial` takes the value of `strap_serial` (1 = serial rewriting, 0 = parallel rewriting). It keeps that value until the next reset.
- R2: While `mrst` is high, both offsets load a preset chosen by {`strap_serial`, `dflt_sel[1]`, `dflt_sel[0]`]. The codes are: 100 gives 1023, 010 gives 511, 001 gives 255, 000 gives 127, 011 gives 63, 110 gives 31, 101 gives 15 and 111 gives 7. A preset above DEPTH-1 is clamped to DEPTH-1.
- R3: In parallel mode, a clock edge with `prog_we` high stores `prog_din`. The first write after reset goes to the empty offset and the next to the full offset, alternating from then on. The new value is visible one cycle after the write edge.
- R4: Any value above DEPTH-1 is stored as DEPTH-1. This applies to both parallel words and completed serial words.
- R5: In serial mode, each edge with `ser_en` high takes one bit from `ser_in`, least significant bit first. The first OFS_W bits form the empty offset and the next OFS_W bits form the full offset, then the cycle repeats. An offset changes only on the edge that delivers its last bit. Cycles with `ser_en` low pause the shift without losing bits already taken.
- R6: In serial mode, `prog_we` has no effect. In parallel mode, `ser_en` has no effect.
- R7: A clock edge with `prog_re` high loads `prog_dout` with an offset value as it stood before that edge. Reads alternate empty, full, empty, and so on from reset, in either mode. `prog_dout` is 0 after reset and holds its value when `prog_re` is low.
- R8: Offsets may be rewritten at any time after reset. They hold their value in every cycle that completes no write.
- R9: Reset clears the write pointer, the read pointer and any partly shifted serial word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for all registers |
| mrst | input | 1 | Synchronous master reset, active high |
| strap_serial | input | 1 | Method strap sampled during reset (1 serial, 0 parallel) |
| dflt_sel | input | 2 | Preset select sampled during reset |
| prog_we | input | 1 | Parallel offset write strobe |
| prog_din | input | OFS_W | Parallel offset write data |
| prog_re | input | 1 | Offset readback strobe |
| prog_dout | output | OFS_W | Registered readback data |
| ser_en | input | 1 | Serial shift enable |
| ser_in | input | 1 | Serial data bit |
| mode_serial | output | 1 | Latched rewrite method |
| empty_ofs | output | OFS_W | Empty offset to the flag logic |
| full_ofs | output | OFS_W | Full offset to the flag logic |

## Verification
Every result is due exactly one clock edge after the stimulus that causes it:
- The straps land on the edge that samples reset.
- A parallel word lands on its write edge.
- A serial offset lands on the edge carrying its last bit.
- Readback data lands on the read edge.

The reference model in the bench advances on the rising edge from the same inputs. The bench compares all four outputs on each falling edge, half a cycle after the update. Because of this, an output that updates one cycle early or late shows up as a mismatch.

// File: rtl/flag_offset_bank.sv
module flag_offset_bank #(
  parameter int DEPTH = 3000,
  parameter int OFS_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             mrst,
  input  logic             strap_serial,
  input  logic [1:0]       dflt_sel,
  input  logic             prog_we,
  input  logic [OFS_W-1:0] prog_din,
  input  logic             prog_re,
  output logic [OFS_W-1:0] prog_dout,
  input  logic             ser_en,
  input  logic             ser_in,
  output logic             mode_serial,
  output logic [OFS_W-1:0] empty_ofs,
  output logic [OFS_W-1:0] full_ofs
);
  localparam int BIT_W = $clog2(OFS_W);
  localparam logic [OFS_W-1:0] MAXV  = OFS_W'(DEPTH - 1);
  localparam logic [BIT_W-1:0] LASTB = BIT_W'(OFS_W - 1);

  logic             wr_sel, rd_sel, ser_half;
  logic [BIT_W-1:0] bit_idx;
  logic [OFS_W-1:0] acc, ser_word, dflt;
  logic             par_wr, ser_wr, ser_last;

  function automatic logic [OFS_W-1:0] clamp(input logic [OFS_W-1:0] v);
    return (v > MAXV) ? MAXV : v;
  endfunction

  function automatic logic [OFS_W-1:0] preset(input logic s, input logic [1:0] sel);
    int v;
    case ({s, sel})
      3'b100:  v = 1023;
      3'b010:  v = 511;
      3'b001:  v = 255;
      3'b000:  v = 127;
      3'b011:  v = 63;
      3'b110:  v = 31;
      3'b101:  v = 15;
      default: v = 7;
    endcase
    return (v > DEPTH - 1) ? MAXV : OFS_W'(v);
  endfunction

  assign dflt     = preset(strap_serial, dflt_sel);
  assign ser_word = {ser_in, acc[OFS_W-1:1]};
  assign par_wr   = !mode_serial && prog_we;
  assign ser_wr   = mode_serial && ser_en;
  assign ser_last = ser_wr && (bit_idx == LASTB);

  always_ff @(posedge clk) begin
    if (mrst) begin
      mode_serial <= strap_serial;
      empty_ofs   <= dflt;
      full_ofs    <= dflt;
      wr_sel      <= 1'b0;
      rd_sel      <= 1'b0;
      ser_half    <= 1'b0;
      bit_idx     <= '0;
      acc         <= '0;
      prog_dout   <= '0;
    end else begin
      if (par_wr) begin
        if (wr_sel) full_ofs  <= clamp(prog_din);
        else        empty_ofs <= clamp(prog_din);
        wr_sel <= !wr_sel;
      end
      if (ser_wr) begin
        acc     <= ser_word;
        bit_idx <= ser_last ? '0 : bit_idx + 1'b1;
        if (ser_last) begin
          ser_half <= !ser_half;
          if (ser_half) full_ofs  <= clamp(ser_word);
          else          empty_ofs <= clamp(ser_word);
        end
      end
      if (prog_re) begin
        prog_dout <= rd_sel ? full_ofs : empty_ofs;
        rd_sel    <= !rd_sel;
      end
    end
  end

  a_r4_in_range: assert property (@(posedge clk) disable iff (mrst)
    (empty_ofs <= MAXV) && (full_ofs <= MAXV));

  a_r1_method_held: assert property (@(posedge clk) disable iff (mrst)
    1'b1 |=> $stable(mode_serial));

  a_r6_serial_ignores_word: assert property (@(posedge clk) disable iff (mrst)
    (mode_serial && !ser_en) |=> ($stable(empty_ofs) && $stable(full_ofs)));

  a_r6_parallel_ignores_shift: assert property (@(posedge clk) disable iff (mrst)
    (!mode_serial && !prog_we) |=> ($stable(empty_ofs) && $stable(full_ofs)));

  a_r5_partial_word_holds: assert property (@(posedge clk) disable iff (mrst)
    (ser_wr && !ser_last) |=> ($stable(empty_ofs) && $stable(full_ofs)));

  a_r7_dout_holds: assert property (@(posedge clk) disable iff (mrst)
    !prog_re |=> $stable(prog_dout));
endmodule

// File: tb/test_flag_offset_bank.sv
`timescale 1ns/1ps
module test_flag_offset_bank;
  localparam int D = 3000;
  localparam int W = $clog2(D);

  logic clk = 1'b0;
  logic mrst = 1'b1, strap_serial = 1'b0, prog_we = 1'b0, prog_re = 1'b0;
  logic ser_en = 1'b0, ser_in = 1'b0;
  logic [1:0] dflt_sel = 2'b00;
  logic [W-1:0] prog_din = '0;
  logic [W-1:0] prog_dout, empty_ofs, full_ofs;
  logic mode_serial;

  flag_offset_bank #(.DEPTH(D), .OFS_W(W)) i_flag_offset_bank (
    .clk(clk), .mrst(mrst), .strap_serial(strap_serial), .dflt_sel(dflt_sel),
    .prog_we(prog_we), .prog_din(prog_din), .prog_re(prog_re), .prog_dout(prog_dout),
    .ser_en(ser_en), .ser_in(ser_in), .mode_serial(mode_serial),
    .empty_ofs(empty_ofs), .full_ofs(full_ofs));

  always #2 clk = ~clk;

  int compared = 0, mismatched = 0, cycles = 0;
  string cur_req = "R2";
  bit started = 0;
  int m_ser, m_e, m_f, m_dout, m_wt, m_rt, m_half, m_idx, m_val;

  function automatic int preset_of(input int s, input int sel);
    int v;
    case (s * 4 + sel)
      4: v = 1023; 2: v = 511; 1: v = 255; 0: v = 127;
      3: v = 63;   6: v = 31;  5: v = 15;  default: v = 7;
    endcase
    return (v > D - 1) ? D - 1 : v;
  endfunction

  function automatic int sat(input int v);
    return (v > D - 1) ? D - 1 : v;
  endfunction

  always @(posedge clk) begin
    if (mrst) begin
      m_ser = strap_serial; m_e = preset_of(strap_serial, dflt_sel); m_f = m_e;
      m_wt = 0; m_rt = 0; m_half = 0; m_idx = 0; m_val = 0; m_dout = 0;
    end else begin
      if (prog_re) begin m_dout = m_rt ? m_f : m_e; m_rt = !m_rt; end
      if (!m_ser && prog_we) begin
        if (m_wt) m_f = sat(prog_din); else m_e = sat(prog_din);
        m_wt = !m_wt;
      end
      if (m_ser && ser_en) begin
        m_val = m_val + (int'(ser_in) << m_idx);
        m_idx++;
        if (m_idx == W) begin
          if (m_half) m_f = sat(m_val); else m_e = sat(m_val);
          m_half = !m_half; m_idx = 0; m_val = 0;
        end
      end
    end
    started = 1;
  end

  task automatic cmp(input string req, input string name, input int act, input int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, name, act, exp);
    end
  endtask

  always @(negedge clk) if (started) begin
    cmp("R1", "mode_serial", mode_serial, m_ser);
    cmp(cur_req, "empty_ofs", empty_ofs, m_e);
    cmp(cur_req, "full_ofs", full_ofs, m_f);
    cmp("R7", "prog_dout", prog_dout, m_dout);
  end

  task automatic do_reset(input logic s, input logic [1:0] sel);
    mrst = 1'b1; strap_serial = s; dflt_sel = sel;
    repeat (2) @(negedge clk);
    mrst = 1'b0; strap_serial = ~s; dflt_sel = ~sel;
    repeat (2) @(negedge clk);
  endtask

  task automatic pwrite(input int v);
    prog_we = 1'b1; prog_din = W'(v); @(negedge clk); prog_we = 1'b0;
  endtask

  task automatic pread();
    prog_re = 1'b1; @(negedge clk); prog_re = 1'b0;
  endtask

  task automatic shift_bits(input int v, input int from, input int to);
    for (int i = from; i <= to; i++) begin
      ser_en = 1'b1; ser_in = v[i]; @(negedge clk);
    end
    ser_en = 1'b0;
  endtask

  task automatic run_random(input int n);
    for (int i = 0; i < n; i++) begin
      prog_we = 1'($urandom); prog_re = 1'($urandom); ser_en = 1'($urandom);
      ser_in = 1'($urandom); prog_din = W'($urandom);
      @(negedge clk);
    end
    prog_we = 0; prog_re = 0; ser_en = 0;
  endtask

  initial begin
    @(negedge clk);
    cur_req = "R2";
    for (int c = 0; c < 8; c++) begin
      do_reset(c[2], c[1:0]);
      pread(); pread();
    end
    do_reset(1'b0, 2'b00);
    cur_req = "R3";
    pwrite(100); pwrite(200); pread(); pread(); pwrite(300); pread();
    cur_req = "R4";
    pwrite(4095); pwrite(3000); pwrite(2999); pwrite(2998); pread(); pread();
    cur_req = "R6";
    shift_bits(4095, 0, W - 1); shift_bits(0, 0, W - 1);
    cur_req = "R8";
    repeat (5) @(negedge clk);
    pwrite(0); prog_we = 1'b1; prog_re = 1'b1; prog_din = W'(77); @(negedge clk);
    prog_we = 0; prog_re = 0;
    cur_req = "R9";
    pwrite(11); do_reset(1'b0, 2'b10); pwrite(12); pread();
    do_reset(1'b1, 2'b01);
    cur_req = "R5";
    shift_bits(555, 0, W - 1); shift_bits(1234, 0, W - 1); pread(); pread();
    shift_bits(4095, 0, 4); repeat (3) @(negedge clk); shift_bits(4095, 5, W - 1);
    shift_bits(3001, 0, W - 1);
    cur_req = "R6";
    pwrite(9); pwrite(10); pread(); pread();
    cur_req = "R9";
    shift_bits(5, 0, 2); do_reset(1'b1, 2'b11); shift_bits(1000, 0, W - 1); pread();
    cur_req = "R8";
    run_random(3000);
    do_reset(1'b0, 2'b01);
    run_random(3000);
    repeat (2) @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 50000) begin
      mismatched++;
      $display("FAIL watchdog actual=%0d expected<=50000 cycles", cycles);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule